// File: doc/BRIEF.md
# USB Endpoint Status Register Bank

This block is the processor-facing register file of a low-speed USB device interface. It holds one register with the device address and an enable flag, and one count/status register for each of three endpoints. A simple processor bus (offset, write strobe, read strobe, write data, combinational read data) reads and writes them. A status port from the packet engine posts the result of each finished transaction: endpoint number, transfer kind, received toggle, error flags and the number of data bytes received.

The block tells the packet engine whether an incoming token's address belongs to this device. It also drives a power-down line for the transceiver. When an endpoint's status changes, the block sends a one-cycle interrupt pulse. The endpoint 0 register guards a posted receive status: once hardware has written it, processor writes are dropped until the processor reads that register.

Top module: `usb_ep_regbank`

## Requirements
- R1: After reset, every register reads 0x00, `xcvr_pd` is 1 and `ep_irq` is 0.
- R2: `addr_match` is 1 exactly when the enable flag (bit 7 of offset 0) is 1 and `tok_addr` equals the 7-bit address in bits 6:0 of offset 0.
- R3: `xcvr_pd` is the inverse of the enable flag. It follows a write to offset 0 from the next cycle on.
- R4: The endpoint registers sit at offsets 1, 3 and 5 for endpoints 0, 1 and 2. Each has the toggle in bit 7, data-valid in bit 6 and the byte count in bits 3:0. Bits 5:4 and every unmapped offset read 0.
- R5: A status update of kind IN (`upd_kind` 0), or of the unused kind 3, leaves the endpoint register unchanged. The processor's writes to toggle, data-valid and count are kept as written.
- R6: A status update of kind OUT (1) or SETUP (2) sets the endpoint's toggle bit to `upd_toggle`.
- R7: An OUT or SETUP update sets the byte count to the number of data bytes plus 2. Data byte counts above 8 are taken as 8, so the stored count is always between 2 and 10.
- R8: An OUT or SETUP update clears data-valid if any of the CRC, bit-stuff or PID error inputs is 1, and sets it otherwise.
- R9: An OUT or SETUP update on endpoint 0 locks that register. While it is locked, processor writes to offset 1 are ignored. A processor read of offset 1 unlocks it. Endpoints 1 and 2 never lock.
- R10: Every status update sends a pulse of exactly one cycle on `ep_irq[upd_ep]` in the cycle after the update, whatever the data validity or the kind. At most one bit of `ep_irq` is set at a time.
- R11: If a status update and a processor write hit the same register in the same cycle, the status update is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (unlocks endpoint 0 when it reads offset 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| upd_valid | input | 1 | Status update strobe from the packet engine |
| upd_ep | input | 2 | Endpoint the update is for |
| upd_kind | input | 2 | 0 IN, 1 OUT, 2 SETUP, 3 unused |
| upd_toggle | input | 1 | Received data toggle |
| upd_err_crc | input | 1 | CRC error seen |
| upd_err_stuff | input | 1 | Bit-stuff error seen |
| upd_err_pid | input | 1 | PID error seen |
| upd_nbytes | input | 4 | Data bytes received, CRC bytes not included |
| tok_addr | input | 7 | Address field of the incoming token |
| addr_match | output | 1 | Token is for this device |
| xcvr_pd | output | 1 | Transceiver power-down |
| ep_irq | output | 3 | Per-endpoint one-cycle status interrupt |

## Verification
The receive path is driven with each error input on its own and with none, so a fault in one error term cannot hide behind another. Data lengths of 0, 8 and 15 probe the +2 offset and the clamp. Both toggle values are posted so a stuck toggle bit is caught. The endpoint 0 lock is tested with a write that must be dropped, then a read, then a write that must land, and endpoint 2 runs the same write sequence to show it does not lock. Address matching is tried with the flag on and off and with an equal and an unequal token address, and a write and an update are made to collide on one register.

// File: rtl/usb_epreg_pkg.sv
// Package: shared encodings for the endpoint status register bank.
// Assumes: three endpoints and 8-bit registers; field positions below are
// decoded by firmware and must not move.
package usb_epreg_pkg;

    typedef enum logic [1:0] {
        XFER_IN    = 2'd0,
        XFER_OUT   = 2'd1,
        XFER_SETUP = 2'd2,
        XFER_RSVD  = 2'd3
    } xfer_kind_e;

    localparam int REG_W      = 8;
    localparam int CNT_W      = 4;
    localparam int DEV_ADDR_W = 7;
    localparam int BIT_TOGGLE = 7;
    localparam int BIT_VALID  = 6;
    localparam int BIT_EN     = 7;
    localparam int CRC_BYTES  = 2;

endpackage

// File: rtl/usb_addr_reg.sv
// Module: device address and enable register.
// Does: stores the enable flag and 7-bit device address, compares token
// addresses against it and drives the transceiver power-down line.
// Assumes: written only through the processor bus; no hardware updates.
module usb_addr_reg
    import usb_epreg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wdata,
    input  logic [DEV_ADDR_W-1:0] tok_addr,
    output logic [REG_W-1:0]      reg_q,
    output logic                  addr_match,
    output logic                  xcvr_pd
);
    logic                  en_q;
    logic [DEV_ADDR_W-1:0] dev_q;

    // Hold the enable flag and address; reset to disabled, address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            dev_q <= '0;
        end else if (wr_en) begin
            en_q  <= wdata[BIT_EN];
            dev_q <= wdata[DEV_ADDR_W-1:0];
        end
    end

    // Present the register image and the token comparison.
    always_comb begin
        reg_q      = {en_q, dev_q};
        addr_match = en_q && (tok_addr == dev_q);
        xcvr_pd    = !en_q;
    end

    AST_MATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> !xcvr_pd); // R2
    AST_PD_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (xcvr_pd == !$past(wdata[BIT_EN]))); // R3

endmodule

// File: rtl/usb_ep_cnt_reg.sv
// Module: one endpoint count/status register.
// Does: takes processor writes and posted receive status; a receive status
// overrides a same-cycle write. With LOCKABLE set, a receive status locks
// the register against writes until the processor reads it.
// Assumes: upd_cnt is already clamped and offset by the CRC bytes.
module usb_ep_cnt_reg
    import usb_epreg_pkg::*;
#(
    parameter bit LOCKABLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [REG_W-1:0] wdata,
    input  logic             upd_hit,
    input  xfer_kind_e       upd_kind,
    input  logic             upd_toggle,
    input  logic             upd_err,
    input  logic [CNT_W-1:0] upd_cnt,
    output logic [REG_W-1:0] reg_q,
    output logic             irq
);
    logic             tog_q;
    logic             valid_q;
    logic [CNT_W-1:0] cnt_q;
    logic             lock_q;
    logic             rx_upd;

    // Decide whether this update carries receive status.
    always_comb rx_upd = upd_hit && (upd_kind == XFER_OUT || upd_kind == XFER_SETUP);

    // Store toggle, valid and count; hardware status has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q   <= 1'b0;
            valid_q <= 1'b0;
            cnt_q   <= '0;
        end else if (rx_upd) begin
            tog_q   <= upd_toggle;
            valid_q <= !upd_err;
            cnt_q   <= upd_cnt;
        end else if (cpu_wr && !lock_q) begin
            tog_q   <= wdata[BIT_TOGGLE];
            valid_q <= wdata[BIT_VALID];
            cnt_q   <= wdata[CNT_W-1:0];
        end
    end

    // Generate the write lock only for the lockable variant.
    generate
        if (LOCKABLE) begin : g_lock
            // Set on receive status, clear on a processor read.
            always_ff @(posedge clk) begin
                if (!rst_n)       lock_q <= 1'b0;
                else if (rx_upd)  lock_q <= 1'b1;
                else if (cpu_rd)  lock_q <= 1'b0;
            end
        end else begin : g_nolock
            always_comb lock_q = 1'b0;
        end
    endgenerate

    // Register a one-cycle interrupt for any update.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= upd_hit;
    end

    // Build the read image; reserved bits read 0.
    always_comb reg_q = {tog_q, valid_q, {(REG_W-2-CNT_W){1'b0}}, cnt_q};

    AST_IN_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_hit && !rx_upd && !cpu_wr) |=> $stable(reg_q)); // R5
    AST_RX_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_upd |=> (reg_q[BIT_TOGGLE] == $past(upd_toggle))); // R6
    AST_RX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_upd |=> (reg_q[CNT_W-1:0] >= 4'd2 && reg_q[CNT_W-1:0] <= 4'd10)); // R7
    AST_RX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_upd |=> (reg_q[BIT_VALID] == !$past(upd_err))); // R8
    AST_LOCK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && cpu_wr && !upd_hit) |=> $stable(reg_q)); // R9
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(upd_hit, 2)) |=> !irq); // R10

endmodule

// File: rtl/usb_ep_regbank.sv
// Module: top of the endpoint status register bank.
// Does: decodes processor offsets, clamps received byte counts, routes
// status updates to the endpoint registers and muxes read data.
// Assumes: offset 0 holds the address register and endpoint i sits at
// offset 2*i+1; at most one status update per cycle.
module usb_ep_regbank
    import usb_epreg_pkg::*;
#(
    parameter int NUM_EP   = 3,
    parameter int MAX_DATA = 8,
    parameter int ADDR_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic                  upd_valid,
    input  logic [1:0]            upd_ep,
    input  logic [1:0]            upd_kind,
    input  logic                  upd_toggle,
    input  logic                  upd_err_crc,
    input  logic                  upd_err_stuff,
    input  logic                  upd_err_pid,
    input  logic [CNT_W-1:0]      upd_nbytes,
    input  logic [DEV_ADDR_W-1:0] tok_addr,
    output logic                  addr_match,
    output logic                  xcvr_pd,
    output logic [NUM_EP-1:0]     ep_irq
);
    localparam logic [CNT_W-1:0] MAX_DATA_C = CNT_W'(MAX_DATA);
    localparam logic [CNT_W-1:0] CRC_C      = CNT_W'(CRC_BYTES);

    logic [REG_W-1:0] addr_reg_q;
    logic [REG_W-1:0] ep_reg_q [NUM_EP];
    logic [CNT_W-1:0] rx_cnt;
    logic             rx_err;
    xfer_kind_e       kind;

    // Clamp the data length and add the CRC bytes; merge error flags.
    always_comb begin
        rx_cnt = ((upd_nbytes > MAX_DATA_C) ? MAX_DATA_C : upd_nbytes) + CRC_C;
        rx_err = upd_err_crc | upd_err_stuff | upd_err_pid;
        kind   = xfer_kind_e'(upd_kind);
    end

    usb_addr_reg u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr && bus_addr == '0),
        .wdata      (bus_wdata),
        .tok_addr   (tok_addr),
        .reg_q      (addr_reg_q),
        .addr_match (addr_match),
        .xcvr_pd    (xcvr_pd)
    );

    // Instantiate one register per endpoint; only endpoint 0 locks.
    generate
        for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
            localparam logic [ADDR_W-1:0] OFS = ADDR_W'(2 * i + 1);
            usb_ep_cnt_reg #(.LOCKABLE(i == 0)) u_ep (
                .clk        (clk),
                .rst_n      (rst_n),
                .cpu_wr     (bus_wr && bus_addr == OFS),
                .cpu_rd     (bus_rd && bus_addr == OFS),
                .wdata      (bus_wdata),
                .upd_hit    (upd_valid && upd_ep == 2'(i)),
                .upd_kind   (kind),
                .upd_toggle (upd_toggle),
                .upd_err    (rx_err),
                .upd_cnt    (rx_cnt),
                .reg_q      (ep_reg_q[i]),
                .irq        (ep_irq[i])
            );
        end
    endgenerate

    // Select read data by offset; unmapped offsets read 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata = addr_reg_q;
        for (int i = 0; i < NUM_EP; i++)
            if (bus_addr == ADDR_W'(2 * i + 1)) bus_rdata = ep_reg_q[i];
    end

    AST_IRQ_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ep_irq)); // R10
    AST_IRQ_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ep_irq != '0)); // R10

endmodule

// File: tb/usb_ep_regbank_tb.sv
module usb_ep_regbank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       upd_valid = 1'b0;
    logic [1:0] upd_ep = '0, upd_kind = '0;
    logic       upd_toggle = 1'b0, upd_err_crc = 1'b0, upd_err_stuff = 1'b0, upd_err_pid = 1'b0;
    logic [3:0] upd_nbytes = '0;
    logic [6:0] tok_addr = '0;
    logic       addr_match, xcvr_pd;
    logic [2:0] ep_irq;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    usb_ep_regbank u_dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compare read data after each read strobe.
    always begin
        @(negedge clk);
        #2;
        if (bus_rd && exp_q.size() > 0)
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end

    task automatic idle();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; upd_valid = 0;
    endtask

    task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_rd = 0; upd_valid = 0;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic cpu_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_wr = 0; upd_valid = 0;
        bus_rd = 1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
    endtask

    task automatic post(input logic [1:0] ep, input logic [1:0] k, input logic tog,
                        input logic [2:0] err, input logic [3:0] n, input bool_wr_keep);
        @(negedge clk);
        if (!bool_wr_keep) bus_wr = 0;
        bus_rd = 0;
        upd_valid = 1; upd_ep = ep; upd_kind = k; upd_toggle = tog;
        {upd_err_crc, upd_err_stuff, upd_err_pid} = err; upd_nbytes = n;
    endtask

    function automatic logic [7:0] rx_img(input logic tog, input logic [2:0] err, input logic [3:0] n);
        logic [3:0] c = ((n > 4'd8) ? 4'd8 : n) + 4'd2;
        return {tog, (err == 3'b000), 2'b00, c};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #2;
        chk("R1 pd", {7'b0, xcvr_pd}, 8'h01);
        chk("R1 irq", {5'b0, ep_irq}, 8'h00);
        chk("R2 match off", {7'b0, addr_match}, 8'h00);
        cpu_rd(0, 8'h00, "R1 addr");
        cpu_rd(1, 8'h00, "R1 ep0");
        cpu_rd(3, 8'h00, "R1 ep1");
        cpu_rd(5, 8'h00, "R1 ep2");
        // Address and enable
        cpu_wr(0, 8'h85);
        idle(); #2;
        chk("R3 pd on", {7'b0, xcvr_pd}, 8'h00);
        tok_addr = 7'h05; #1;
        chk("R2 match", {7'b0, addr_match}, 8'h01);
        tok_addr = 7'h06; #1;
        chk("R2 mismatch", {7'b0, addr_match}, 8'h00);
        cpu_rd(0, 8'h85, "R2 addr readback");
        cpu_wr(0, 8'h05);
        idle(); #2;
        tok_addr = 7'h05; #1;
        chk("R2 match disabled", {7'b0, addr_match}, 8'h00);
        chk("R3 pd off", {7'b0, xcvr_pd}, 8'h01);
        // Map and reserved bits
        cpu_wr(3, 8'hFF);
        cpu_rd(3, 8'hCF, "R4 reserved bits");
        cpu_rd(2, 8'h00, "R4 unmapped 2");
        cpu_rd(7, 8'h00, "R4 unmapped 7");
        // IN update keeps contents, still interrupts
        post(1, 0, 0, 3'b000, 4'd3, 0);
        idle(); #2;
        chk("R10 irq ep1", {5'b0, ep_irq}, 8'h02);
        idle(); #2;
        chk("R10 irq single", {5'b0, ep_irq}, 8'h00);
        cpu_rd(3, 8'hCF, "R5 IN unchanged");
        post(1, 3, 0, 3'b000, 4'd3, 0);
        cpu_rd(3, 8'hCF, "R5 kind3 unchanged");
        // Receive updates on ep1
        post(1, 1, 1, 3'b000, 4'd8, 0);
        cpu_rd(3, rx_img(1, 3'b000, 8), "R6 R7 R8 out 8");
        post(1, 1, 0, 3'b100, 4'd0, 0);
        cpu_rd(3, rx_img(0, 3'b100, 0), "R8 crc err");
        post(1, 2, 1, 3'b010, 4'd5, 0);
        cpu_rd(3, rx_img(1, 3'b010, 5), "R8 stuff err");
        post(1, 1, 0, 3'b001, 4'd15, 0);
        cpu_rd(3, rx_img(0, 3'b001, 15), "R7 clamp pid err");
        // Endpoint 0 lock
        post(0, 2, 0, 3'b000, 4'd8, 0);
        idle(); #2;
        chk("R10 irq ep0", {5'b0, ep_irq}, 8'h01);
        cpu_wr(1, 8'h83);
        cpu_rd(1, 8'h4A, "R9 locked write dropped");
        cpu_wr(1, 8'h83);
        cpu_rd(1, 8'h83, "R9 write after unlock");
        // Endpoint 2 never locks
        post(2, 1, 1, 3'b000, 4'd1, 0);
        idle(); #2;
        chk("R10 irq ep2", {5'b0, ep_irq}, 8'h04);
        cpu_wr(5, 8'h07);
        cpu_rd(5, 8'h07, "R9 ep2 no lock");
        // Collision: update wins
        cpu_wr(5, 8'h8F);
        post(2, 1, 0, 3'b000, 4'd4, 1);
        cpu_rd(5, rx_img(0, 3'b000, 4), "R11 update wins");
        idle(); idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule